// File: doc/BRIEF.md
# Iterative DES block cipher engine

This block enciphers or deciphers 64-bit words with the Data Encryption Standard, one Feistel round per clock. A free-running round counter advances on every enabled cycle: in the counter's first step the engine takes in the data word, the key word and the direction select, and it applies the initial permutation and the first round in that same cycle. Fifteen further enabled cycles finish the remaining rounds. The swapped halves then pass through the inverse initial permutation into the result register, and a strobe marks that result for one cycle. The next block is taken in on the following enabled cycle, so a steady stream moves one 64-bit word every 16 cycles.

Round subkeys are derived on the fly from a registered copy of the two 28-bit key halves. For encryption the halves rotate left. For decryption they start unrotated and rotate right, so the same datapath produces the subkeys in reverse order. A low run enable freezes every piece of state, and processing resumes where it stopped. A synchronous clear drops the block in flight at any point.

Top module: `des_iter_core`

## Requirements
- R1: Bits 0, 8, 16, 24, 32, 40, 48 and 56 of `key_in` (the last bit of every key byte) have no effect on the result.
- R2: With `run_en` held at 1, the inputs are taken in on the cycle the counter is at its start, and `out_valid` rises exactly 16 enabled cycles later. Blocks follow one another every 16 cycles with no gap.
- R3: With `encrypt` = 1 the result is the DES ciphertext of `data_in` under `key_in`. Example: key 133457799BBCDFF1 and data 0123456789ABCDEF give 85E813540F0AB405.
- R4: With `encrypt` = 0 the result is the DES decryption, so a ciphertext is restored to its plaintext. The select is sampled only when a block is taken in.
- R5: While `run_en` = 0, the counter, the round state, the key state and the result hold, and input changes during that time are not taken in. After resume, the block completes with the value it would have had without the pause, late by exactly the number of paused cycles.
- R6: `clr` = 1 on an edge returns the counter to its start and drops the block in flight, and no strobe follows for it. This holds even on the last round, and `clr` wins over `run_en`. The next block is taken in on the first enabled cycle after the clear.
- R7: An active-low asynchronous `rst_n` forces `out_valid` and `data_out` to 0 without waiting for a clock edge. Afterwards the counter is at its start.
- R8: `out_valid` is high for exactly one cycle per completed block, including when `run_en` drops during the strobe, and `data_out` changes only on the edge that raises the strobe.
- R9: Bit 63 of every 64-bit port carries DES bit 1 (the most significant bit), and bit 0 carries DES bit 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| clk | input | 1 | Clock |
| run_en | input | 1 | 1 runs, 0 freezes all state |
| clr | input | 1 | Synchronous abort and counter restart |
| encrypt | input | 1 | 1 encrypt, 0 decrypt, sampled when a block is taken in |
| key_in | input | 64 | Key word, byte parity bits ignored |
| data_in | input | 64 | Data word to transform |
| data_out | output | 64 | Result, meaningful while `out_valid` is 1 |
| out_valid | output | 1 | One-cycle strobe marking a completed block |

## Verification
The hardest case to reach is a freeze or abort that lands on an exact round. Examples are a pause on the very cycle a block is taken in, a pause on the cycle right after the strobe, and a clear on the sixteenth round, where the strobe must not appear. The bench keeps its own model of the round phase, so its stimulus can steer to a chosen phase before it drops `run_en` or raises `clr`. It also changes the data and key during a pause, which shows that nothing is taken in while the block is frozen. Results are predicted from a small table of known DES answers, looked up with the parity bits masked off.

// File: rtl/des_iter_pkg.sv
package des_iter_pkg;

   localparam int BLK_W  = 64;
   localparam int HALF_W = 32;
   localparam int CD_W   = 56;
   localparam int HC_W   = 28;
   localparam int SK_W   = 48;
   localparam int SB_N   = 8;

   typedef logic [BLK_W-1:0]  blk_t;
   typedef logic [HALF_W-1:0] half_t;
   typedef logic [CD_W-1:0]   cd_t;
   typedef logic [HC_W-1:0]   hc_t;
   typedef logic [SK_W-1:0]   subkey_t;

   // Tables use DES numbering: entry n names input bit n, bit 1 = MSB.
   localparam int unsigned IP_T [64] = '{
      58, 50, 42, 34, 26, 18, 10,  2, 60, 52, 44, 36, 28, 20, 12,  4,
      62, 54, 46, 38, 30, 22, 14,  6, 64, 56, 48, 40, 32, 24, 16,  8,
      57, 49, 41, 33, 25, 17,  9,  1, 59, 51, 43, 35, 27, 19, 11,  3,
      61, 53, 45, 37, 29, 21, 13,  5, 63, 55, 47, 39, 31, 23, 15,  7};

   localparam int unsigned P_T [32] = '{
      16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
       2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25};

   localparam int unsigned PC1_T [56] = '{
      57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
      10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
      63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
      14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

   localparam int unsigned PC2_T [48] = '{
      14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
      23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
      41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
      44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

   // Substitution boxes, row-major: index = row*16 + column.
   localparam int unsigned SB1 [64] = '{
      14, 4,13, 1, 2,15,11, 8, 3,10, 6,12, 5, 9, 0, 7,
       0,15, 7, 4,14, 2,13, 1,10, 6,12,11, 9, 5, 3, 8,
       4, 1,14, 8,13, 6, 2,11,15,12, 9, 7, 3,10, 5, 0,
      15,12, 8, 2, 4, 9, 1, 7, 5,11, 3,14,10, 0, 6,13};
   localparam int unsigned SB2 [64] = '{
      15, 1, 8,14, 6,11, 3, 4, 9, 7, 2,13,12, 0, 5,10,
       3,13, 4, 7,15, 2, 8,14,12, 0, 1,10, 6, 9,11, 5,
       0,14, 7,11,10, 4,13, 1, 5, 8,12, 6, 9, 3, 2,15,
      13, 8,10, 1, 3,15, 4, 2,11, 6, 7,12, 0, 5,14, 9};
   localparam int unsigned SB3 [64] = '{
      10, 0, 9,14, 6, 3,15, 5, 1,13,12, 7,11, 4, 2, 8,
      13, 7, 0, 9, 3, 4, 6,10, 2, 8, 5,14,12,11,15, 1,
      13, 6, 4, 9, 8,15, 3, 0,11, 1, 2,12, 5,10,14, 7,
       1,10,13, 0, 6, 9, 8, 7, 4,15,14, 3,11, 5, 2,12};
   localparam int unsigned SB4 [64] = '{
       7,13,14, 3, 0, 6, 9,10, 1, 2, 8, 5,11,12, 4,15,
      13, 8,11, 5, 6,15, 0, 3, 4, 7, 2,12, 1,10,14, 9,
      10, 6, 9, 0,12,11, 7,13,15, 1, 3,14, 5, 2, 8, 4,
       3,15, 0, 6,10, 1,13, 8, 9, 4, 5,11,12, 7, 2,14};
   localparam int unsigned SB5 [64] = '{
       2,12, 4, 1, 7,10,11, 6, 8, 5, 3,15,13, 0,14, 9,
      14,11, 2,12, 4, 7,13, 1, 5, 0,15,10, 3, 9, 8, 6,
       4, 2, 1,11,10,13, 7, 8,15, 9,12, 5, 6, 3, 0,14,
      11, 8,12, 7, 1,14, 2,13, 6,15, 0, 9,10, 4, 5, 3};
   localparam int unsigned SB6 [64] = '{
      12, 1,10,15, 9, 2, 6, 8, 0,13, 3, 4,14, 7, 5,11,
      10,15, 4, 2, 7,12, 9, 5, 6, 1,13,14, 0,11, 3, 8,
       9,14,15, 5, 2, 8,12, 3, 7, 0, 4,10, 1,13,11, 6,
       4, 3, 2,12, 9, 5,15,10,11,14, 1, 7, 6, 0, 8,13};
   localparam int unsigned SB7 [64] = '{
       4,11, 2,14,15, 0, 8,13, 3,12, 9, 7, 5,10, 6, 1,
      13, 0,11, 7, 4, 9, 1,10,14, 3, 5,12, 2,15, 8, 6,
       1, 4,11,13,12, 3, 7,14,10,15, 6, 8, 0, 5, 9, 2,
       6,11,13, 8, 1, 4,10, 7, 9, 5, 0,15,14, 2, 3,12};
   localparam int unsigned SB8 [64] = '{
      13, 2, 8, 4, 6,15,11, 1,10, 9, 3,14, 5, 0,12, 7,
       1,15,13, 8,10, 3, 7, 4,12, 5, 6,11, 0,14, 9, 2,
       7,11, 4, 1, 9,12,14, 2, 0, 6,10,13,15, 3, 5, 8,
       2, 1,14, 7, 4,10, 8,13,15,12, 9, 0, 3, 5, 6,11};

   function automatic blk_t init_perm(blk_t x);
      blk_t y;
      for (int i = 0; i < 64; i++) y[63-i] = x[64-IP_T[i]];
      return y;
   endfunction

   // Inverse of init_perm, derived from the same table.
   function automatic blk_t final_perm(blk_t x);
      blk_t y;
      for (int i = 0; i < 64; i++) y[64-IP_T[i]] = x[63-i];
      return y;
   endfunction

   // Each 6-bit group g takes half bits 4g .. 4g+5 (1-based, wrapping).
   function automatic subkey_t expand(half_t x);
      subkey_t y;
      for (int g = 0; g < SB_N; g++)
         for (int p = 0; p < 6; p++)
            y[SK_W-1-(6*g+p)] = x[HALF_W-1-((4*g+p+HALF_W-1) % HALF_W)];
      return y;
   endfunction

   function automatic half_t p_perm(half_t x);
      half_t y;
      for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-P_T[i]];
      return y;
   endfunction

   function automatic cd_t key_select(blk_t k);
      cd_t y;
      for (int i = 0; i < CD_W; i++) y[CD_W-1-i] = k[64-PC1_T[i]];
      return y;
   endfunction

   function automatic subkey_t key_compress(cd_t cd);
      subkey_t y;
      for (int i = 0; i < SK_W; i++) y[SK_W-1-i] = cd[CD_W-PC2_T[i]];
      return y;
   endfunction

   function automatic logic [3:0] sbox_val(int box, logic [5:0] six);
      int unsigned idx;
      int unsigned v;
      idx = {26'd0, six[5], six[0], six[4:1]};
      case (box)
         0:       v = SB1[idx];
         1:       v = SB2[idx];
         2:       v = SB3[idx];
         3:       v = SB4[idx];
         4:       v = SB5[idx];
         5:       v = SB6[idx];
         6:       v = SB7[idx];
         default: v = SB8[idx];
      endcase
      return v[3:0];
   endfunction

   // Rotation before round rnd (1..16). Encrypt rotates left by the
   // standard amount; decrypt starts unrotated, then rotates right by
   // the amount of the mirrored encrypt round.
   function automatic int unsigned rot_amount(int unsigned rnd, logic enc);
      int unsigned j;
      if (!enc && rnd == 1) return 0;
      j = enc ? rnd : 18 - rnd;
      return (j == 1 || j == 2 || j == 9 || j == 16) ? 1 : 2;
   endfunction

   function automatic hc_t rotate_half(hc_t x, int unsigned amt, logic left);
      hc_t y;
      y = x;
      for (int s = 0; s < 2; s++)
         if (s < int'(amt))
            y = left ? {y[HC_W-2:0], y[HC_W-1]} : {y[0], y[HC_W-1:1]};
      return y;
   endfunction

endpackage

// File: rtl/des_iter_ctrl.sv
module des_iter_ctrl #(
   parameter int ROUNDS = 16,
   parameter int CNT_W  = $clog2(ROUNDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             clr,
   output logic             load,
   output logic             last,
   output logic [CNT_W:0]   rnd,
   output logic             out_valid
);

   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ROUNDS-1);

   logic [CNT_W-1:0] cnt;

   assign load = (cnt == '0);
   assign last = (cnt == LAST_CNT);
   assign rnd  = {1'b0, cnt} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         out_valid <= 1'b0;
      end else if (clr) begin
         cnt       <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= run_en && last;
         if (run_en) cnt <= last ? '0 : cnt + 1'b1;
      end
   end

   a_r5_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !clr) |=> $stable(cnt));
   a_r6_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0 && !out_valid));
   a_r2_strobe_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !clr && last) |=> out_valid);
   a_r2_no_early_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(run_en && !clr && last) |=> !out_valid);
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

endmodule

// File: rtl/des_iter_keysched.sv
module des_iter_keysched
   import des_iter_pkg::*;
#(
   parameter int KEY_W = 64,
   parameter int RND_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             clr,
   input  logic             load,
   input  logic             enc,
   input  logic [KEY_W-1:0] key_in,
   input  logic [RND_W-1:0] rnd,
   output subkey_t          subkey
);

   if (KEY_W != BLK_W) begin : g_bad_key_w
      $error("des_iter_keysched: KEY_W must be 64");
   end

   cd_t         cd_q;
   cd_t         cd_base;
   cd_t         cd_next;
   int unsigned amt;

   assign cd_base = load ? key_select(key_in) : cd_q;
   assign amt     = rot_amount(32'(rnd), enc);
   assign cd_next = {rotate_half(cd_base[CD_W-1:HC_W], amt, enc),
                     rotate_half(cd_base[HC_W-1:0],    amt, enc)};
   assign subkey  = key_compress(cd_next);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cd_q <= '0;
      else if (clr)    cd_q <= '0;
      else if (run_en) cd_q <= cd_next;
   end

   a_r5_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !clr) |=> $stable(cd_q));

endmodule

// File: rtl/des_iter_feistel.sv
module des_iter_feistel
   import des_iter_pkg::*;
(
   input  half_t   r_in,
   input  subkey_t subkey,
   output half_t   f_out
);

   subkey_t mixed;
   half_t   sub_out;

   assign mixed = expand(r_in) ^ subkey;

   for (genvar g = 0; g < SB_N; g++) begin : g_sbox
      assign sub_out[HALF_W-1-4*g -: 4] = sbox_val(g, mixed[SK_W-1-6*g -: 6]);
   end

   assign f_out = p_perm(sub_out);

endmodule

// File: rtl/des_iter_core.sv
module des_iter_core
   import des_iter_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int KEY_W  = 64,
   parameter int ROUNDS = 16
) (
   input  logic              rst_n,
   input  logic              clk,
   input  logic              run_en,
   input  logic              clr,
   input  logic              encrypt,
   input  logic [KEY_W-1:0]  key_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              out_valid
);

   localparam int CNT_W = $clog2(ROUNDS);
   localparam int RND_W = CNT_W + 1;

   if (DATA_W != BLK_W) begin : g_bad_data_w
      $error("des_iter_core: DATA_W must be 64");
   end
   if (ROUNDS != 16) begin : g_bad_rounds
      $error("des_iter_core: ROUNDS must be 16");
   end

   logic             load;
   logic             last;
   logic [RND_W-1:0] rnd;
   logic             mode_q;
   logic             mode_eff;
   subkey_t          subkey;
   blk_t             lr_q;
   blk_t             lr_in;
   half_t            f_val;
   half_t            r_new;

   des_iter_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .clr       (clr),
      .load      (load),
      .last      (last),
      .rnd       (rnd),
      .out_valid (out_valid)
   );

   assign mode_eff = load ? encrypt : mode_q;

   des_iter_keysched #(.KEY_W(KEY_W), .RND_W(RND_W)) u_keys (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_en (run_en),
      .clr    (clr),
      .load   (load),
      .enc    (mode_eff),
      .key_in (key_in),
      .rnd    (rnd),
      .subkey (subkey)
   );

   assign lr_in = load ? init_perm(data_in) : lr_q;

   des_iter_feistel u_f (
      .r_in   (lr_in[HALF_W-1:0]),
      .subkey (subkey),
      .f_out  (f_val)
   );

   assign r_new = lr_in[BLK_W-1:HALF_W] ^ f_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_q     <= '0;
         mode_q   <= 1'b0;
         data_out <= '0;
      end else if (clr) begin
         lr_q   <= '0;
         mode_q <= 1'b0;
      end else if (run_en) begin
         lr_q   <= {lr_in[HALF_W-1:0], r_new};
         mode_q <= mode_eff;
         if (last) data_out <= final_perm({r_new, lr_in[HALF_W-1:0]});
      end
   end

   a_r5_round_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !clr) |=> ($stable(lr_q) && $stable(mode_q)));
   a_r8_result_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |=> ($stable(data_out) || out_valid));
   a_r4_mode_held_midblock: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !clr && !load && !last) |=> $stable(mode_q));

endmodule

// File: tb/des_iter_core_tb.sv
`timescale 1ns/1ps
module des_iter_core_tb;

   logic        rst_n = 1'b0;
   logic        clk = 1'b0;
   logic        run_en = 1'b0;
   logic        clr = 1'b0;
   logic        encrypt = 1'b1;
   logic [63:0] key_in = '0;
   logic [63:0] data_in = '0;
   logic [63:0] data_out;
   logic        out_valid;

   always #2 clk = ~clk;

   des_iter_core u_dut (
      .rst_n (rst_n), .clk (clk), .run_en (run_en), .clr (clr),
      .encrypt (encrypt), .key_in (key_in), .data_in (data_in),
      .data_out (data_out), .out_valid (out_valid)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   int    strobes = 0;
   string tag = "R7";

   // Behavioural model state.
   int          phase = 0;
   logic        exp_v = 1'b0;
   logic [63:0] exp_q = '0;
   logic [63:0] blk_exp = '0;
   bit          blk_ok = 1'b0;

   localparam logic [63:0] PAR = 64'h0101010101010101;
   localparam logic [63:0] K1 = 64'h133457799BBCDFF1, P1 = 64'h0123456789ABCDEF, C1 = 64'h85E813540F0AB405;
   localparam logic [63:0] K2 = 64'h0E329232EA6D0D73, P2 = 64'h8787878787878787, C2 = 64'h0000000000000000;
   localparam logic [63:0] K3 = 64'h0000000000000000, P3 = 64'h0000000000000000, C3 = 64'h8CA64DE9C1B123A7;

   function automatic bit known(logic [63:0] k, logic [63:0] d, logic e, output logic [63:0] r);
      logic [63:0] km;
      km = k & ~PAR;
      r = '0;
      if (km == (K1 & ~PAR)) begin
         if (e && d == P1) begin r = C1; return 1; end
         if (!e && d == C1) begin r = P1; return 1; end
      end
      if (km == (K2 & ~PAR)) begin
         if (e && d == P2) begin r = C2; return 1; end
         if (!e && d == C2) begin r = P2; return 1; end
      end
      if (km == (K3 & ~PAR)) begin
         if (e && d == P3) begin r = C3; return 1; end
         if (!e && d == C3) begin r = P3; return 1; end
      end
      return 0;
   endfunction

   task automatic check(input string t, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", t, act, exp);
      end
   endtask

   task automatic set_in(input logic [63:0] k, input logic [63:0] d, input logic e);
      key_in = k; data_in = d; encrypt = e;
   endtask

   // Called at a falling edge: drive, predict the next rising edge, check.
   task automatic cyc(input logic e, input logic c);
      run_en = e; clr = c;
      if (c) begin
         phase = 0; exp_v = 1'b0;
      end else if (e) begin
         if (phase == 0) blk_ok = known(key_in, data_in, encrypt, blk_exp);
         exp_v = (phase == 15);
         if (phase == 15) exp_q = blk_exp;
         phase = (phase + 1) % 16;
      end else begin
         exp_v = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      check({tag, " strobe"}, {63'd0, out_valid}, {63'd0, exp_v});
      if (exp_v) begin
         strobes++;
         if (blk_ok) check({tag, " result"}, data_out, exp_q);
      end
   endtask

   task automatic go_phase(input int p);
      while (phase != p) cyc(1'b1, 1'b0);
   endtask

   initial begin
      int s0;
      // R7: reset state
      repeat (3) @(negedge clk);
      check("R7 reset strobe", {63'd0, out_valid}, 64'd0);
      check("R7 reset result", data_out, 64'd0);
      rst_n = 1'b1;

      tag = "R3 R9 encrypt";
      set_in(K1, P1, 1'b1);
      repeat (40) cyc(1'b1, 1'b0);

      tag = "R4 decrypt";
      set_in(K1, C1, 1'b0);
      repeat (34) cyc(1'b1, 1'b0);

      tag = "R1 parity bits";
      set_in(K1 ^ PAR, P1, 1'b1);
      repeat (32) cyc(1'b1, 1'b0);
      set_in(K3 ^ PAR, C3, 1'b0);
      repeat (32) cyc(1'b1, 1'b0);

      tag = "R3 vectors";
      set_in(K2, P2, 1'b1); repeat (32) cyc(1'b1, 1'b0);
      set_in(K3, P3, 1'b1); repeat (32) cyc(1'b1, 1'b0);
      tag = "R4 vectors";
      set_in(K2, C2, 1'b0); repeat (32) cyc(1'b1, 1'b0);
      set_in(K3, C3, 1'b0); repeat (32) cyc(1'b1, 1'b0);

      tag = "R5 pause midblock";
      set_in(K1, P1, 1'b1);
      go_phase(0); go_phase(5);
      set_in(K2, P2, 1'b0);
      repeat (9) cyc(1'b0, 1'b0);
      set_in(K2, P2, 1'b1);
      repeat (40) cyc(1'b1, 1'b0);
      tag = "R5 pause at intake";
      go_phase(0);
      set_in(K3, P3, 1'b1);
      repeat (4) cyc(1'b0, 1'b0);
      repeat (20) cyc(1'b1, 1'b0);

      tag = "R8 pause during strobe";
      while (!(phase == 0 && exp_v)) cyc(1'b1, 1'b0);
      repeat (3) cyc(1'b0, 1'b0);
      repeat (20) cyc(1'b1, 1'b0);

      tag = "R6 clear midblock";
      set_in(K1, C1, 1'b0);
      go_phase(8); cyc(1'b1, 1'b1);
      repeat (20) cyc(1'b1, 1'b0);
      tag = "R6 clear while paused";
      go_phase(3); cyc(1'b0, 1'b1);
      repeat (20) cyc(1'b1, 1'b0);
      tag = "R6 clear on last round";
      go_phase(15); cyc(1'b1, 1'b1);
      repeat (20) cyc(1'b1, 1'b0);

      tag = "R7 async reset midblock";
      go_phase(10);
      rst_n = 1'b0;
      #1;
      check("R7 async strobe", {63'd0, out_valid}, 64'd0);
      check("R7 async result", data_out, 64'd0);
      @(negedge clk);
      rst_n = 1'b1; phase = 0; exp_v = 1'b0;
      repeat (20) cyc(1'b1, 1'b0);

      tag = "R2 back-to-back";
      set_in(K2, P2, 1'b1);
      go_phase(0);
      s0 = strobes;
      repeat (64) cyc(1'b1, 1'b0);
      check("R2 strobe count", 64'(strobes - s0), 64'd4);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule